// File: doc/BRIEF.md
# Shared 64-bit Timebase with Per-Core Compare Timers

This block keeps one free-running counter that all cores of a cluster share, and gives every core its own compare register and timer-pending flag. The counter is wider than the 32-bit register bus, so software sees it as a low word and a high word at two addresses. The block never holds a snapshot of the counter between the two half-reads. Software gets a coherent value by reading high, low and high again, and retrying if the two high words differ. The counter width is set at build time as 32 plus four times a width field, and a read-only information register reports that field. The counter wraps to zero at the top of its range.

Every bus request carries the number of the core that issues it. Local compare, pending and window-select registers are private to that core. A core writes a target core number into its window-select register. From then on, the window addresses reach that target's compare halves and pending flag. A shared halt bit freezes the counter. Software may also load either half of the counter, which lets it set up the counter and test the wrap.

The register port is a plain request strobe with a registered read response. It has no back-pressure: the block accepts a request in every cycle, and a read returns its data one cycle later.

Top module: `shctr_timer`

## Requirements
- R1: After reset the counter is 0, the halt bit is 0, every window select is 0, every compare register holds all ones of the counter width (so the high half reads 0x0000FFFF at the default width), and all timer-pending flags are 0.
- R2: While halt (bit 0 of address 0x1) is 0, the counter grows by exactly one per clock. While halt is 1, it holds its value.
- R3: The counter width is 32 + 4*WFIELD bits. Past its maximum value it wraps to zero. Address 0x0 reads WFIELD in bits 3:0 and the core count minus one in bits 11:8, so the default build reads 0x304.
- R4: Address 0x2 reads counter bits 31:0 and address 0x3 reads bits 63:32. Bits above the counter width read as zero. Each half-read samples the live counter with no latching across reads. Writing either address loads that half of the counter, with the bits above the width dropped.
- R5: Addresses 0x4 and 0x5 write and read back the low and high halves of the requesting core's compare value. Bits above the counter width are dropped.
- R6: A core's pending flag sets in the cycle after the counter equals that core's compare value, and stays set. It is visible on timer_pend[core] and as bit 0 of address 0x6.
- R7: A write to either compare half of a core clears that core's pending flag. If a match occurs in the same cycle, the write still wins.
- R8: Address 0x7 holds the requesting core's window target. Addresses 0x8, 0x9 and 0xA reach the target core's compare low, compare high and pending flag, exactly as that core's own 0x4, 0x5 and 0x6 do.
- R9: A read request gives rsp_valid with its data on the next cycle. Write requests give no response. Unmapped addresses read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request strobe, taken every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CORE_W | Number of the core issuing the request |
| req_addr | input | 4 | Word address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| timer_pend | output | NCORE | Per-core timer-pending flags |

## Verification
A wrong counter shows up as a half-read that breaks the one-per-cycle arithmetic, or as a wrong wrap value, on the first read after the fault. A corrupted compare register or a mis-decoded window target shows up as a wrong readback from the target core's local address, on the first read after the write. A faulty pending flag appears on timer_pend one cycle after the matching counter value, or stays high after a compare write. The bench checks the pending flag both on that port and through the window address.

// File: rtl/shctr_pkg.sv
package shctr_pkg;
  typedef enum logic [3:0] {
    A_INFO    = 4'h0,
    A_CTL     = 4'h1,
    A_CNT_LO  = 4'h2,
    A_CNT_HI  = 4'h3,
    A_CMP_LO  = 4'h4,
    A_CMP_HI  = 4'h5,
    A_PEND    = 4'h6,
    A_SEL     = 4'h7,
    A_XCMP_LO = 4'h8,
    A_XCMP_HI = 4'h9,
    A_XPEND   = 4'hA
  } reg_addr_e;

  function automatic logic [63:0] width_mask(input int w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) if (i < w) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/shctr_count.sv
module shctr_count #(
  parameter int CNT_W = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cnt
);
  localparam logic [63:0] CMASK = shctr_pkg::width_mask(CNT_W);

  logic [63:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)      cnt_d = {cnt_q[63:32], wdata};
    else if (wr_hi) cnt_d = {wdata, cnt_q[31:0]};
    else if (!halt) cnt_d = cnt_q + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d & CMASK;
  end

  assign cnt = cnt_q;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !wr_lo && !wr_hi) |=> (((cnt_q - $past(cnt_q)) & CMASK) == 64'd1));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  // R3
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !wr_lo && !wr_hi && cnt_q == CMASK) |=> (cnt_q == 64'd0));
  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q & ~CMASK) == 64'd0));
endmodule

// File: rtl/shctr_slot.sv
module shctr_slot #(
  parameter int CNT_W = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] cnt,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cmp,
  output logic        pend
);
  localparam logic [63:0] CMASK = shctr_pkg::width_mask(CNT_W);

  logic [63:0] cmp_q, cmp_d;
  logic        pend_q;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[31:0]  = wdata;
    if (wr_hi) cmp_d[63:32] = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= CMASK;
      pend_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d & CMASK;
      if (wr_lo || wr_hi)    pend_q <= 1'b0;
      else if (cnt == cmp_q) pend_q <= 1'b1;
    end
  end

  assign cmp  = cmp_q;
  assign pend = pend_q;

  // R6
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cnt == cmp_q));
  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_lo && !wr_hi) |=> pend_q);
  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |=> !pend_q);
endmodule

// File: rtl/shctr_timer.sv
module shctr_timer #(
  parameter int NCORE  = 4,
  parameter int WFIELD = 4,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int CNT_W  = 32 + 4 * WFIELD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CORE_W-1:0] req_core,
  input  logic [3:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [NCORE-1:0]  timer_pend
);
  import shctr_pkg::*;

  logic              wr, rd;
  logic              halt_q;
  logic [63:0]       cnt;
  logic [63:0]       cmp_w [NCORE];
  logic [CORE_W-1:0] sel_q [NCORE];
  logic [CORE_W-1:0] tgt;
  logic [31:0]       rdata_d, rdata_q;
  logic              rsp_q;

  assign wr  = req_valid && req_write;
  assign rd  = req_valid && !req_write;
  assign tgt = sel_q[req_core];

  always_ff @(posedge clk) begin
    if (!rst_n)                        halt_q <= 1'b0;
    else if (wr && req_addr == A_CTL)  halt_q <= req_wdata[0];
  end

  shctr_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (halt_q),
    .wr_lo (wr && req_addr == A_CNT_LO),
    .wr_hi (wr && req_addr == A_CNT_HI),
    .wdata (req_wdata),
    .cnt   (cnt)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic own, via;
    assign own = wr && (req_core == CORE_W'(c));
    assign via = wr && (tgt == CORE_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n)                              sel_q[c] <= '0;
      else if (own && req_addr == A_SEL)       sel_q[c] <= req_wdata[CORE_W-1:0];
    end

    shctr_slot #(.CNT_W(CNT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .wr_lo ((own && req_addr == A_CMP_LO) || (via && req_addr == A_XCMP_LO)),
      .wr_hi ((own && req_addr == A_CMP_HI) || (via && req_addr == A_XCMP_HI)),
      .wdata (req_wdata),
      .cmp   (cmp_w[c]),
      .pend  (timer_pend[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    case (req_addr)
      A_INFO:    rdata_d = {20'd0, 4'(NCORE - 1), 4'd0, 4'(WFIELD)};
      A_CTL:     rdata_d = {31'd0, halt_q};
      A_CNT_LO:  rdata_d = cnt[31:0];
      A_CNT_HI:  rdata_d = cnt[63:32];
      A_CMP_LO:  rdata_d = cmp_w[req_core][31:0];
      A_CMP_HI:  rdata_d = cmp_w[req_core][63:32];
      A_PEND:    rdata_d = {31'd0, timer_pend[req_core]};
      A_SEL:     rdata_d = 32'(tgt);
      A_XCMP_LO: rdata_d = cmp_w[tgt][31:0];
      A_XCMP_HI: rdata_d = cmp_w[tgt][63:32];
      A_XPEND:   rdata_d = {31'd0, timer_pend[tgt]};
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  // R9
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  // R9
  no_rsp_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  // R4
  hi_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == A_CNT_HI) |=> ((rsp_rdata >> (CNT_W - 32)) == 32'd0));
  // R6
  pend_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (req_addr == A_PEND || req_addr == A_XPEND)) |=> (rsp_rdata[31:1] == 31'd0));
endmodule

// File: tb/tb_shctr_timer.sv
`timescale 1ns/1ps
module tb_shctr_timer;
  localparam int NCORE = 4;
  localparam int CW    = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [CW-1:0] req_core;
  logic [3:0]    req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NCORE-1:0] timer_pend;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  shctr_timer #(.NCORE(NCORE), .WFIELD(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .timer_pend(timer_pend)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int core, input logic [3:0] addr, input logic [31:0] data);
    req_valid = 1'b1; req_write = 1'b1; req_core = CW'(core);
    req_addr = addr; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int core, input logic [3:0] addr, output logic [31:0] data);
    req_valid = 1'b1; req_write = 1'b0; req_core = CW'(core);
    req_addr = addr; req_wdata = '0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
    data = rsp_rdata;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    req_valid = 0; req_write = 0; req_core = 0; req_addr = 0; req_wdata = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    check("R1 pending after reset", {28'd0, timer_pend}, 32'd0);
    check("R9 no response idle", {31'd0, rsp_valid}, 32'd0);
    rd(3, 4'h4, v); check("R1 compare lo reset", v, 32'hFFFF_FFFF);
    rd(3, 4'h5, v); check("R1 compare hi reset", v, 32'h0000_FFFF);
    rd(1, 4'h7, v); check("R1 window select reset", v, 32'd0);
    rd(0, 4'h1, v); check("R1 halt reset", v, 32'd0);
    rd(0, 4'h0, v); check("R3 info register", v, 32'h0000_0304);

    // R9 unmapped address and write without response
    wr(0, 4'hF, 32'h1234_5678);
    check("R9 no response to write", {31'd0, rsp_valid}, 32'd0);
    rd(0, 4'hF, v); check("R9 unmapped reads zero", v, 32'd0);

    // R2 / R4: halt, preset counter, run, verify arithmetic
    wr(0, 4'h1, 32'd1);
    wr(0, 4'h3, 32'd0);
    wr(0, 4'h2, 32'd100);
    idle(4);
    rd(2, 4'h2, v); check("R2 halted counter holds", v, 32'd100);
    wr(0, 4'h1, 32'd0);            // edge e0
    rd(1, 4'h2, v);                // e1
    rd(1, 4'h2, v2);               // e2
    check("R4 first live read", v, 32'd100);
    check("R4 second read not latched", v2, 32'd101);
    idle(5);                       // e3..e7
    rd(3, 4'h2, v);                // e8
    check("R2 count per cycle", v, 32'd107);

    // R3 / R4 wrap at 48 bits
    wr(0, 4'h1, 32'd1);
    wr(0, 4'h3, 32'hFFFF_FFFF);
    rd(0, 4'h3, v); check("R4 high bits above width dropped", v, 32'h0000_FFFF);
    wr(0, 4'h2, 32'hFFFF_FFFD);
    wr(0, 4'h1, 32'd0);            // e0
    idle(3);                       // e1..e3
    wr(0, 4'h1, 32'd1);            // e4: four increments
    rd(0, 4'h3, v); check("R3 wrap high word", v, 32'd0);
    rd(0, 4'h2, v); check("R3 wrap low word", v, 32'd1);

    // R5 / R8 sweep: every target written through another core's window
    for (int t = 0; t < NCORE; t++) begin
      int w;
      w = (t + 1) % NCORE;
      wr(w, 4'h7, 32'(t));
      wr(w, 4'h8, 32'h1000_0000 + 32'(t) * 32'h111);
      wr(w, 4'h9, 32'hFFFF_FF00 + 32'(t));
      rd(t, 4'h4, v); check("R8 window write reaches target lo", v, 32'h1000_0000 + 32'(t) * 32'h111);
      rd(t, 4'h5, v); check("R5 compare hi masked", v, (32'hFFFF_FF00 + 32'(t)) & 32'h0000_FFFF);
      rd(w, 4'h8, v); check("R8 window readback", v, 32'h1000_0000 + 32'(t) * 32'h111);
    end
    // R5 local writes
    for (int c = 0; c < NCORE; c++) begin
      wr(c, 4'h4, 32'hA000_0000 + 32'(c));
      wr(c, 4'h5, 32'h0000_0200 + 32'(c));
    end
    for (int c = 0; c < NCORE; c++) begin
      rd(c, 4'h4, v); check("R5 local compare lo", v, 32'hA000_0000 + 32'(c));
      rd(c, 4'h5, v); check("R5 local compare hi", v, 32'h0000_0200 + 32'(c));
    end
    check("R6 no pending without match", {28'd0, timer_pend}, 32'd0);

    // R6 match with counter halted at 1
    wr(1, 4'h5, 32'd0);
    wr(1, 4'h4, 32'd1);
    idle(1);
    check("R6 pending port", {28'd0, timer_pend}, 32'b0010);
    rd(1, 4'h6, v); check("R6 pending register", v, 32'd1);
    rd(0, 4'h6, v); check("R6 other core not pending", v, 32'd0);
    wr(0, 4'h1, 32'd0);
    idle(3);
    wr(0, 4'h1, 32'd1);
    check("R6 pending sticky", {31'd0, timer_pend[1]}, 32'd1);

    // R7 compare write clears pending
    wr(1, 4'h4, 32'h0000_0500);
    idle(1);
    check("R7 compare write clears", {31'd0, timer_pend[1]}, 32'd0);
    rd(1, 4'h6, v); check("R7 pending register cleared", v, 32'd0);

    // R8 pending through the window
    wr(0, 4'h3, 32'd0);
    wr(0, 4'h2, 32'h0000_0042);
    wr(0, 4'h7, 32'd3);
    wr(0, 4'h9, 32'd0);
    wr(0, 4'h8, 32'h0000_0042);
    idle(1);
    rd(0, 4'hA, v); check("R8 window pending", v, 32'd1);
    rd(0, 4'h6, v); check("R8 selecting core not pending", v, 32'd0);
    check("R8 target pending port", {28'd0, timer_pend}, 32'b1000);
    wr(0, 4'h9, 32'd7);
    idle(1);
    check("R7 window write clears target", {28'd0, timer_pend}, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule